// File: doc/BRIEF.md
# Reference Clock Source Selector

This block decides which clock feeds the parallel input path of a camera-link serializer. It runs on the free-running internal oscillator. The incoming pixel clock and the external oscillator input are treated as asynchronous waveforms. Each is brought into the internal domain through a two-flop synchronizer and then edge-detected. Pixel-clock activity is measured over fixed windows of internal-oscillator cycles. The block moves to the pixel clock once activity is seen, and falls back to the internal oscillator when activity stops. A software override bit keeps it on the internal oscillator.

When the external-oscillator strap is set, two pins change function. One pin becomes the oscillator input. The other carries the oscillator divided by two, which is the reference sent to the imager. The block also counts pixel-clock edges over a fixed number of oscillator periods and flags whether the pixel clock holds the ratio that the selected pixel mode requires. When the strap is clear, both pins forward remote GPIO values as usual.

Top module: `refclk_selector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `use_pclk`, `ratio_ok` and `ref_div_out` are 0.
- R2: Each activity window lasts WIN_LEN (64) internal cycles. A window that contains at least PRESENT_MIN (4) synchronized pixel-clock rising edges sets the presence state when it closes. `use_pclk` then rises on the next cycle, provided `hold_internal` is 0.
- R3: Presence clears only when two windows in a row close with zero pixel-clock edges. A window with 1 to PRESENT_MIN-1 edges leaves presence unchanged and restarts the count of empty windows.
- R4: While `hold_internal` is 1, `use_pclk` is 0 from the following cycle on, whatever the pixel-clock activity.
- R5: With `xo_strap` = 1, `ref_div_out` toggles one cycle after each synchronized rising edge of `osc_in`. With `xo_strap` = 0, it is held at 0.
- R6: With `xo_strap` = 1, a ratio window closes on every RATIO_PERIODS-th (64th) oscillator rising edge. At that point `ratio_ok` becomes 1 if the number of pixel-clock edges in the window is within ±RATIO_TOL (2) of the target, and 0 otherwise. The target depends on `pix_mode`: 2'b00 (10-bit) gives 128, 2'b01 (12-bit high frequency) gives 96, and 2'b10 (12-bit low frequency) gives 64. The code 2'b11 never passes. `ratio_ok` changes only when a window closes.
- R7: With `xo_strap` = 0, `ratio_ok` is 0 from the next cycle on and the ratio counters are cleared.
- R8: With `xo_strap` = 1, `gpo2_out` equals `ref_div_out`, `gpo3_oe` is 0 (the pin is an input) and `gpo3_out` is 0. With `xo_strap` = 0, `gpo2_out` equals `remote_gpio2`, `gpo3_out` equals `remote_gpio3` and `gpo3_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator; clock for all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | External oscillator waveform (asynchronous) |
| pclk_in | input | 1 | Pixel clock waveform from the imager (asynchronous) |
| pix_mode | input | 2 | Pixel mode: 00 10-bit, 01 12-bit HF, 10 12-bit LF, 11 reserved |
| hold_internal | input | 1 | Override bit: 1 keeps the internal oscillator selected |
| xo_strap | input | 1 | External-oscillator mode enable strap |
| remote_gpio2 | input | 1 | Remote GPIO value normally forwarded on pin 2 |
| remote_gpio3 | input | 1 | Remote GPIO value normally forwarded on pin 3 |
| use_pclk | output | 1 | 1 = pixel clock selected, 0 = internal oscillator |
| ref_div_out | output | 1 | Oscillator divided by two (imager reference) |
| ratio_ok | output | 1 | Pixel clock to oscillator ratio within tolerance |
| gpo2_out | output | 1 | Pin 2 output value |
| gpo3_out | output | 1 | Pin 3 output value |
| gpo3_oe | output | 1 | Pin 3 output enable (0 = input for the oscillator) |

## Verification
The activity windows and the ratio windows run on independent counters, so a presence decision and a ratio decision can close in the same cycle. In that cycle the override bit can also flip. To provoke these coincidences, the bench runs both measurements at once with the strap set, and it toggles `hold_internal` every cycle across several activity-window boundaries. A behavioural reference model, built on integers, predicts `use_pclk`, `ratio_ok`, `ref_div_out` and the pin outputs each cycle. Every cycle is judged against it, so any coincident update that is lost or ordered wrongly shows up as a mismatch.

// File: rtl/refclk_sel_pkg.sv
package refclk_sel_pkg;

    typedef enum logic [1:0] {
        PM_RAW10    = 2'b00,
        PM_RAW12_HF = 2'b01,
        PM_RAW12_LF = 2'b10,
        PM_RESERVED = 2'b11
    } pix_mode_e;

    // Expected pixel-clock edge count over 'periods' oscillator periods; -1 = never valid
    function automatic int ratio_target(pix_mode_e m, int periods);
        case (m)
            PM_RAW10:    return 2 * periods;
            PM_RAW12_HF: return (3 * periods) / 2;
            PM_RAW12_LF: return periods;
            default:     return -1;
        endcase
    endfunction

endpackage

// File: rtl/rcs_edge_sync.sv
module rcs_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // sh_q[1] is the second synchronizer stage; sh_q[2] its previous value
    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/rcs_activity.sv
module rcs_activity #(
    parameter int WIN_LEN     = 64,
    parameter int PRESENT_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk_rise,
    output logic present
);
    localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int EW = $clog2(PRESENT_MIN + 1);

    typedef struct packed {
        logic [WW-1:0] wcnt;
        logic [EW-1:0] ecnt;
        logic          quiet;
        logic          present;
    } act_t;

    act_t act_d, act_q;
    logic win_end;
    int   total;

    always_comb begin
        act_d   = act_q;
        win_end = (act_q.wcnt == WW'(WIN_LEN - 1));
        total   = int'(act_q.ecnt) + (pclk_rise ? 1 : 0);
        if (win_end) begin
            act_d.wcnt = '0;
            act_d.ecnt = '0;
            if (total >= PRESENT_MIN) begin
                act_d.present = 1'b1;
                act_d.quiet   = 1'b0;
            end else if (total == 0) begin
                if (act_q.quiet) act_d.present = 1'b0;
                act_d.quiet = 1'b1;
            end else begin
                act_d.quiet = 1'b0;
            end
        end else begin
            act_d.wcnt = act_q.wcnt + WW'(1);
            if (pclk_rise && (act_q.ecnt != EW'(PRESENT_MIN)))
                act_d.ecnt = act_q.ecnt + EW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign present = act_q.present;

    // R2: presence is only ever gained when a window closes
    a_r2_rise_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q.present) |-> $past(win_end));

    // R3: a second empty window in a row clears presence
    a_r3_drop_after_two_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && total == 0 && act_q.quiet) |=> !act_q.present);

    // R3: presence never moves between window boundaries
    a_r3_hold_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(act_q.present));
endmodule

// File: rtl/rcs_ratio.sv
module rcs_ratio
    import refclk_sel_pkg::*;
#(
    parameter int RATIO_PERIODS = 64,
    parameter int RATIO_TOL     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       xclk_rise,
    input  logic       pclk_rise,
    input  logic [1:0] mode,
    output logic       div_clk,
    output logic       ratio_ok
);
    localparam int XW   = (RATIO_PERIODS > 1) ? $clog2(RATIO_PERIODS) : 1;
    localparam int PW   = $clog2(2 * RATIO_PERIODS + RATIO_TOL + 1) + 1;
    localparam logic [PW-1:0] PMAX = '1;

    typedef struct packed {
        logic [XW-1:0] xcnt;
        logic [PW-1:0] pcnt;
        logic          div;
        logic          ok;
    } rat_t;

    rat_t rat_d, rat_q;
    logic win_close;
    logic in_range;
    int   total;
    int   target;

    always_comb begin
        rat_d     = rat_q;
        win_close = enable && xclk_rise && (rat_q.xcnt == XW'(RATIO_PERIODS - 1));
        total     = int'(rat_q.pcnt) + (pclk_rise ? 1 : 0);
        target    = ratio_target(pix_mode_e'(mode), RATIO_PERIODS);
        in_range  = (target >= 0) && (total >= target - RATIO_TOL) &&
                    (total <= target + RATIO_TOL);
        if (!enable) begin
            rat_d = '0;
        end else begin
            if (xclk_rise) rat_d.div = ~rat_q.div;
            if (win_close) begin
                rat_d.ok   = in_range;
                rat_d.xcnt = '0;
                rat_d.pcnt = '0;
            end else begin
                if (xclk_rise) rat_d.xcnt = rat_q.xcnt + XW'(1);
                if (pclk_rise && (rat_q.pcnt != PMAX))
                    rat_d.pcnt = rat_q.pcnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rat_q <= '0;
        else        rat_q <= rat_d;
    end

    assign div_clk  = rat_q.div;
    assign ratio_ok = rat_q.ok;

    // R5: each oscillator edge flips the divided output
    a_r5_div_follows_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && xclk_rise) |=> (rat_q.div != $past(rat_q.div)));

    // R5: no oscillator edge, no change
    a_r5_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !xclk_rise) |=> $stable(rat_q.div));

    // R7: no ratio verdict without the strap
    a_r7_no_ok_without_strap: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rat_q.ok);

    // R6: the verdict only moves when a window closes
    a_r6_ok_moves_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !win_close) |=> $stable(rat_q.ok));
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector #(
    parameter int WIN_LEN       = 64,
    parameter int PRESENT_MIN   = 4,
    parameter int RATIO_PERIODS = 64,
    parameter int RATIO_TOL     = 2
) (
    input  logic       clk_int,
    input  logic       rst_n,
    input  logic       osc_in,
    input  logic       pclk_in,
    input  logic [1:0] pix_mode,
    input  logic       hold_internal,
    input  logic       xo_strap,
    input  logic       remote_gpio2,
    input  logic       remote_gpio3,
    output logic       use_pclk,
    output logic       ref_div_out,
    output logic       ratio_ok,
    output logic       gpo2_out,
    output logic       gpo3_out,
    output logic       gpo3_oe
);
    localparam int NSYNC = 2;   // index 0: pixel clock, index 1: oscillator

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] rise_s;
    logic             present;
    logic             div_clk;

    assign raw_in = {osc_in, pclk_in};

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        rcs_edge_sync u_sync (
            .clk      (clk_int),
            .rst_n    (rst_n),
            .async_in (raw_in[g]),
            .rise     (rise_s[g])
        );
    end

    rcs_activity #(
        .WIN_LEN     (WIN_LEN),
        .PRESENT_MIN (PRESENT_MIN)
    ) u_activity (
        .clk       (clk_int),
        .rst_n     (rst_n),
        .pclk_rise (rise_s[0]),
        .present   (present)
    );

    rcs_ratio #(
        .RATIO_PERIODS (RATIO_PERIODS),
        .RATIO_TOL     (RATIO_TOL)
    ) u_ratio (
        .clk       (clk_int),
        .rst_n     (rst_n),
        .enable    (xo_strap),
        .xclk_rise (rise_s[1]),
        .pclk_rise (rise_s[0]),
        .mode      (pix_mode),
        .div_clk   (div_clk),
        .ratio_ok  (ratio_ok)
    );

    typedef struct packed {
        logic sel;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d     = top_q;
        top_d.sel = present & ~hold_internal;
    end

    always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign use_pclk    = top_q.sel;
    assign ref_div_out = div_clk;

    // Pin function: the strap hands both pins to the clocking path
    always_comb begin
        gpo2_out = xo_strap ? div_clk : remote_gpio2;
        gpo3_out = xo_strap ? 1'b0    : remote_gpio3;
        gpo3_oe  = ~xo_strap;
    end

    // R4: an override seen at an edge keeps the internal oscillator selected
    a_r4_override_keeps_internal: assert property (@(posedge clk_int) disable iff (!rst_n)
        $past(hold_internal) |-> !use_pclk);

    // R2: switching to the pixel clock needs measured activity
    a_r2_select_needs_activity: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(use_pclk) |-> $past(present));
endmodule

// File: tb/refclk_selector_test.sv
module refclk_selector_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_in = 1'b0;
    logic       pclk_in = 1'b0;
    logic [1:0] pix_mode = 2'b00;
    logic       hold_internal = 1'b0;
    logic       xo_strap = 1'b0;
    logic       remote_gpio2 = 1'b0;
    logic       remote_gpio3 = 1'b0;
    logic       use_pclk, ref_div_out, ratio_ok, gpo2_out, gpo3_out, gpo3_oe;

    int total = 0;
    int bad = 0;
    int p_half = 0, p_cnt = 0;
    int x_half = 0, x_cnt = 0;

    // reference model state
    bit m_p1, m_p2, m_p3, m_x1, m_x2, m_x3;
    int m_win, m_edges, m_quiet_run;
    bit m_present, m_use;
    int m_xper, m_pedges;
    bit m_div, m_ok;

    refclk_selector uut (
        .clk_int (clk), .rst_n (rst_n), .osc_in (osc_in), .pclk_in (pclk_in),
        .pix_mode (pix_mode), .hold_internal (hold_internal), .xo_strap (xo_strap),
        .remote_gpio2 (remote_gpio2), .remote_gpio3 (remote_gpio3),
        .use_pclk (use_pclk), .ref_div_out (ref_div_out), .ratio_ok (ratio_ok),
        .gpo2_out (gpo2_out), .gpo3_out (gpo3_out), .gpo3_oe (gpo3_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int target_for(logic [1:0] m);
        case (m)
            2'b00:   return 128;
            2'b01:   return 96;
            2'b10:   return 64;
            default: return -1000;
        endcase
    endfunction

    // waveform generators for the asynchronous inputs
    always @(negedge clk) begin
        if (p_half > 0) begin
            p_cnt++;
            if (p_cnt >= p_half) begin pclk_in = ~pclk_in; p_cnt = 0; end
        end
        if (x_half > 0) begin
            x_cnt++;
            if (x_cnt >= x_half) begin osc_in = ~osc_in; x_cnt = 0; end
        end
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            {m_p1, m_p2, m_p3, m_x1, m_x2, m_x3} = '0;
            m_win = 0; m_edges = 0; m_quiet_run = 0; m_present = 0; m_use = 0;
            m_xper = 0; m_pedges = 0; m_div = 0; m_ok = 0;
        end else begin
            bit pe, xe;
            pe = m_p2 && !m_p3;
            xe = m_x2 && !m_x3;
            m_use = m_present && !hold_internal;
            // activity windows
            m_edges += pe ? 1 : 0;
            if (m_win == 63) begin
                if (m_edges >= 4) begin m_present = 1; m_quiet_run = 0; end
                else if (m_edges == 0) begin
                    m_quiet_run++;
                    if (m_quiet_run >= 2) m_present = 0;
                end else m_quiet_run = 0;
                m_win = 0; m_edges = 0;
            end else m_win++;
            // ratio measurement
            if (!xo_strap) begin
                m_xper = 0; m_pedges = 0; m_div = 0; m_ok = 0;
            end else begin
                m_pedges += pe ? 1 : 0;
                if (xe) begin
                    m_div = !m_div;
                    if (m_xper == 63) begin
                        int diff;
                        diff = m_pedges - target_for(pix_mode);
                        m_ok = (diff >= -2) && (diff <= 2);
                        m_xper = 0; m_pedges = 0;
                    end else m_xper++;
                end
            end
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pclk_in;
            m_x3 = m_x2; m_x2 = m_x1; m_x1 = osc_in;
        end
    end

    // cycle-by-cycle comparison, away from the edge
    always @(posedge clk) begin
        #1;
        check("R2 use_pclk vs model", int'(use_pclk), int'(m_use));
        check("R6 ratio_ok vs model", int'(ratio_ok), int'(m_ok));
        check("R5 ref_div_out vs model", int'(ref_div_out), int'(m_div));
        check("R8 gpo2_out vs model", int'(gpo2_out), xo_strap ? int'(m_div) : int'(remote_gpio2));
        check("R8 gpo3_out vs model", int'(gpo3_out), xo_strap ? 0 : int'(remote_gpio3));
        check("R8 gpo3_oe vs model", int'(gpo3_oe), xo_strap ? 0 : 1);
    end

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cycles(4);
        check("R1 use_pclk in reset", int'(use_pclk), 0);
        check("R1 ratio_ok in reset", int'(ratio_ok), 0);
        check("R1 ref_div_out in reset", int'(ref_div_out), 0);
        rst_n = 1'b1;
        wait_cycles(1);
        check("R1 use_pclk after reset", int'(use_pclk), 0);

        // strap clear: pins forward remote values
        remote_gpio2 = 1'b1; remote_gpio3 = 1'b1;
        wait_cycles(1);
        check("R8 gpo2 forwards remote", int'(gpo2_out), 1);
        check("R8 gpo3 forwards remote", int'(gpo3_out), 1);
        check("R8 gpo3 driven", int'(gpo3_oe), 1);

        // pixel clock appears
        p_half = 3;
        wait_cycles(200);
        check("R2 pixel clock selected", int'(use_pclk), 1);
        hold_internal = 1'b1;
        wait_cycles(2);
        check("R4 override forces internal", int'(use_pclk), 0);
        hold_internal = 1'b0;
        wait_cycles(2);
        check("R4 release returns to pixel clock", int'(use_pclk), 1);

        // oscillator runs but strap is clear
        x_half = 6;
        wait_cycles(900);
        check("R7 no ratio verdict without strap", int'(ratio_ok), 0);
        check("R5 divider idle without strap", int'(ref_div_out), 0);

        // sparse activity keeps presence
        p_half = 40;
        wait_cycles(400);
        check("R3 sparse edges keep selection", int'(use_pclk), 1);
        p_half = 0;
        wait_cycles(200);
        check("R3 lost activity falls back", int'(use_pclk), 0);

        // external-oscillator mode, 10-bit ratio
        xo_strap = 1'b1; pix_mode = 2'b00; p_half = 3;
        wait_cycles(1800);
        check("R6 10-bit ratio 2 passes", int'(ratio_ok), 1);
        check("R8 gpo3 released as input", int'(gpo3_oe), 0);
        check("R8 gpo2 carries divided clock", int'(gpo2_out), int'(ref_div_out));

        // coincident override flips while both measurements run
        for (int i = 0; i < 200; i++) begin
            hold_internal = ~hold_internal;
            wait_cycles(1);
        end
        hold_internal = 1'b0;

        pix_mode = 2'b01; p_half = 4;
        wait_cycles(1800);
        check("R6 12-bit HF ratio 1.5 passes", int'(ratio_ok), 1);
        pix_mode = 2'b10; p_half = 6;
        wait_cycles(1800);
        check("R6 12-bit LF ratio 1 passes", int'(ratio_ok), 1);
        pix_mode = 2'b00;
        wait_cycles(1800);
        check("R6 wrong ratio fails", int'(ratio_ok), 0);
        pix_mode = 2'b11; p_half = 3;
        wait_cycles(1800);
        check("R6 reserved mode never passes", int'(ratio_ok), 0);

        xo_strap = 1'b0;
        wait_cycles(2);
        check("R7 strap clear drops verdict", int'(ratio_ok), 0);
        check("R5 strap clear holds divider low", int'(ref_div_out), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule